// File: doc/BRIEF.md
# Branch Resolution Unit for a 64-bit Packet-Filter Core

This block decides the control flow of one jump-class instruction of a 64-bit packet-filter virtual machine. The issue stage hands it the 8-bit opcode, the destination register value, the source register value, the sign-extended immediate, a 16-bit signed displacement and the current program counter. The block reports whether the branch is taken and which instruction comes next. The program counter counts instructions, not bytes.

Conditional and unconditional jumps always finish in exactly two cycles. Program exit finishes in one cycle. A call has no implementation inside the block. The block raises a request to an external handler and waits for that handler's completion strobe, so a call never finishes in fewer than two cycles. Only one instruction is in flight at a time. The core may issue the next instruction in the same cycle that the previous result is reported.

Top module: `bru_top`

## Requirements
- R1: After a synchronous active-low reset, `in_ready` is 1, `out_done` is 0 and `call_req` is 0.
- R2: For a jump opcode, low nibble 0x5 selects `in_imm` as the second operand and low nibble 0xD selects `in_src`; the unselected value has no effect.
- R3: Opcode 0x05 (unconditional jump) is always taken.
- R4: High nibble 0x1 is taken when the operands are equal, 0x5 when they differ, and 0x4 when their bitwise AND is nonzero.
- R5: High nibbles 0x2, 0x3, 0xA and 0xB compare the destination against the second operand as unsigned numbers: greater, greater-or-equal, less, less-or-equal.
- R6: High nibbles 0x6, 0x7, 0xC and 0xD make the same four comparisons on two's-complement signed values.
- R7: `out_next_pc` equals pc + 1 + sign-extended displacement when the branch is taken and pc + 1 otherwise, modulo 2^PC_W.
- R8: A jump accepted at clock edge k raises `out_done` for one cycle after edge k+1, and `in_ready` is 0 between those edges.
- R9: Opcode 0x95 (exit) raises `out_done` with `out_exit`=1 after the accepting edge itself, with `out_taken`=0 and `out_next_pc` equal to the issuing pc.
- R10: Opcode 0x85 (call) holds `call_req` high from the cycle after acceptance until `call_done` is sampled high. `out_done` follows one cycle later with `out_next_pc` = pc + 1, so a call takes at least two cycles.
- R11: `call_done` has no effect unless a call is waiting.
- R12: Any other opcode completes in two cycles as a not-taken jump with `out_next_pc` = pc + 1. This covers high nibbles 0x0 with low nibble 0xD, 0x8 or 0x9 with low nibble 0xD, 0xE and 0xF, and any low nibble other than 0x5 or 0xD.
- R13: `in_ready` is 1 in the cycle that shows `out_done`, so a new instruction can be accepted in the same cycle that the previous one is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction present on the issue inputs |
| in_ready | output | 1 | Block idle; instruction accepted when in_valid is also 1 |
| in_opcode | input | 8 | Instruction opcode |
| in_dst | input | XLEN (64) | Destination register value |
| in_src | input | XLEN (64) | Source register value |
| in_imm | input | XLEN (64) | Sign-extended immediate |
| in_off | input | OFF_W (16) | Signed branch displacement in instructions |
| in_pc | input | PC_W (32) | Program counter of the issuing instruction |
| out_done | output | 1 | One-cycle result strobe |
| out_taken | output | 1 | Branch taken (valid with out_done) |
| out_exit | output | 1 | Completed instruction was an exit |
| out_next_pc | output | PC_W (32) | Program counter of the next instruction |
| call_req | output | 1 | Request to the external call handler |
| call_done | input | 1 | Handler completion strobe |

## Verification
Two functions can fall in the same cycle: the result report of one instruction and the acceptance of the next. The bench waits for the `out_done` of a jump, drives a new jump in that same cycle, and judges that the pending result is intact, that `in_ready` is high, and that the second jump completes with its own two-cycle latency and target. A second collision is a stray `call_done` strobe that arrives while a jump is being evaluated. The bench judges it by the jump's unchanged result and by `call_req` staying low.

// File: rtl/bru_pkg.sv
// Package: shared types for the branch resolution unit.
// Assumes opcodes follow the jump-class encoding: low three bits 3'b101.
package bru_pkg;

    // Instruction kind after decode
    typedef enum logic [1:0] {
        K_JUMP = 2'd0,
        K_CALL = 2'd1,
        K_EXIT = 2'd2,
        K_BAD  = 2'd3
    } kind_e;

    // Branch condition after decode
    typedef enum logic [3:0] {
        C_ALWAYS = 4'd0,
        C_EQ     = 4'd1,
        C_GT     = 4'd2,
        C_GE     = 4'd3,
        C_SET    = 4'd4,
        C_NE     = 4'd5,
        C_SGT    = 4'd6,
        C_SGE    = 4'd7,
        C_LT     = 4'd8,
        C_LE     = 4'd9,
        C_SLT    = 4'd10,
        C_SLE    = 4'd11,
        C_NEVER  = 4'd12
    } cond_e;

    // Operand-select low nibbles
    localparam logic [3:0] LO_IMM = 4'h5;
    localparam logic [3:0] LO_REG = 4'hD;

endpackage

// File: rtl/bru_decode.sv
// Module: bru_decode
// Turns a jump-class opcode into an instruction kind, a condition and
// an operand select. Purely combinational. Assumes only the encodings
// listed in the brief are legal; anything else decodes to K_BAD/C_NEVER.
module bru_decode
    import bru_pkg::*;
(
    input  logic [7:0] op,
    output kind_e      kind,
    output cond_e      cond,
    output logic       use_reg
);

    logic lo_ok;
    logic lo_imm;

    assign lo_imm  = (op[3:0] == LO_IMM);
    assign lo_ok   = lo_imm || (op[3:0] == LO_REG);
    assign use_reg = (op[3:0] == LO_REG);

    // Map high nibble to kind and condition
    always_comb begin
        kind = K_BAD;
        cond = C_NEVER;
        if (lo_ok) begin
            kind = K_JUMP;
            case (op[7:4])
                4'h0: begin
                    if (lo_imm) cond = C_ALWAYS;
                    else        kind = K_BAD;
                end
                4'h1: cond = C_EQ;
                4'h2: cond = C_GT;
                4'h3: cond = C_GE;
                4'h4: cond = C_SET;
                4'h5: cond = C_NE;
                4'h6: cond = C_SGT;
                4'h7: cond = C_SGE;
                4'h8: kind = lo_imm ? K_CALL : K_BAD;
                4'h9: kind = lo_imm ? K_EXIT : K_BAD;
                4'hA: cond = C_LT;
                4'hB: cond = C_LE;
                4'hC: cond = C_SLT;
                4'hD: cond = C_SLE;
                default: kind = K_BAD;
            endcase
        end
    end

endmodule

// File: rtl/bru_compare.sv
// Module: bru_compare
// Evaluates one branch condition on two W-bit operands.
// Purely combinational; assumes the operands are already selected.
module bru_compare
    import bru_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  cond_e        cond,
    output logic         hit
);

    logic eq, ult, slt;

    assign eq  = (a == b);
    assign ult = (a < b);
    assign slt = ($signed(a) < $signed(b));

    // Select the result for the requested condition
    always_comb begin
        case (cond)
            C_ALWAYS: hit = 1'b1;
            C_EQ:     hit = eq;
            C_NE:     hit = !eq;
            C_SET:    hit = |(a & b);
            C_GT:     hit = !ult && !eq;
            C_GE:     hit = !ult;
            C_LT:     hit = ult;
            C_LE:     hit = ult || eq;
            C_SGT:    hit = !slt && !eq;
            C_SGE:    hit = !slt;
            C_SLT:    hit = slt;
            C_SLE:    hit = slt || eq;
            default:  hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/bru_target.sv
// Module: bru_target
// Computes the next program counter in instruction units:
// pc + 1 + sext(off) when taken, else pc + 1, wrapping at PC_W bits.
// Assumes PC_W is larger than OFF_W.
module bru_target #(
    parameter int PC_W  = 32,
    parameter int OFF_W = 16
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [OFF_W-1:0] off,
    input  logic             taken,
    output logic [PC_W-1:0]  next_pc
);

    localparam int EXT_W = PC_W - OFF_W;

    logic [PC_W-1:0] off_ext;
    logic [PC_W-1:0] step;

    assign off_ext = {{EXT_W{off[OFF_W-1]}}, off};

    // Pick the displacement, then add the sequential increment
    always_comb begin
        step    = taken ? off_ext : '0;
        next_pc = pc + step + PC_W'(1);
    end

endmodule

// File: rtl/bru_top.sv
// Module: bru_top
// Branch resolution unit. Accepts one jump-class instruction at a time.
// Jumps report after two edges, exit after one, and a call after its
// external handler strobes call_done. Assumes the issue stage keeps
// inputs stable only in the accepting cycle.
module bru_top
    import bru_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int PC_W  = 32,
    parameter int OFF_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [7:0]       in_opcode,
    input  logic [XLEN-1:0]  in_dst,
    input  logic [XLEN-1:0]  in_src,
    input  logic [XLEN-1:0]  in_imm,
    input  logic [OFF_W-1:0] in_off,
    input  logic [PC_W-1:0]  in_pc,
    output logic             out_done,
    output logic             out_taken,
    output logic             out_exit,
    output logic [PC_W-1:0]  out_next_pc,
    output logic             call_req,
    input  logic             call_done
);

    typedef enum logic [1:0] {S_IDLE, S_EVAL, S_CALL} state_e;

    state_e            st;
    kind_e             dec_kind;
    cond_e             dec_cond;
    logic              dec_use_reg;
    cond_e             r_cond;
    logic [XLEN-1:0]   r_a, r_b;
    logic [PC_W-1:0]   r_pc;
    logic [OFF_W-1:0]  r_off;
    logic              hit;
    logic              tgt_taken;
    logic [PC_W-1:0]   tgt_pc;
    logic              accept;

    assign in_ready  = (st == S_IDLE);
    assign accept    = in_valid && in_ready;
    assign tgt_taken = hit && (st == S_EVAL);

    bru_decode u_dec (
        .op      (in_opcode),
        .kind    (dec_kind),
        .cond    (dec_cond),
        .use_reg (dec_use_reg)
    );

    bru_compare #(.W(XLEN)) u_cmp (
        .a    (r_a),
        .b    (r_b),
        .cond (r_cond),
        .hit  (hit)
    );

    bru_target #(.PC_W(PC_W), .OFF_W(OFF_W)) u_tgt (
        .pc      (r_pc),
        .off     (r_off),
        .taken   (tgt_taken),
        .next_pc (tgt_pc)
    );

    // Capture the issued instruction and its selected operands
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_cond <= C_NEVER;
            r_a    <= '0;
            r_b    <= '0;
            r_pc   <= '0;
            r_off  <= '0;
        end else if (accept) begin
            r_cond <= dec_cond;
            r_a    <= in_dst;
            r_b    <= dec_use_reg ? in_src : in_imm;
            r_pc   <= in_pc;
            r_off  <= in_off;
        end
    end

    // Sequence the instruction and produce the result strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= S_IDLE;
            out_done    <= 1'b0;
            out_taken   <= 1'b0;
            out_exit    <= 1'b0;
            out_next_pc <= '0;
            call_req    <= 1'b0;
        end else begin
            out_done <= 1'b0;
            case (st)
                S_IDLE: begin
                    if (accept) begin
                        case (dec_kind)
                            K_EXIT: begin
                                out_done    <= 1'b1;
                                out_exit    <= 1'b1;
                                out_taken   <= 1'b0;
                                out_next_pc <= in_pc;
                            end
                            K_CALL: begin
                                call_req <= 1'b1;
                                st       <= S_CALL;
                            end
                            default: st <= S_EVAL;
                        endcase
                    end
                end
                S_EVAL: begin
                    out_done    <= 1'b1;
                    out_taken   <= hit;
                    out_exit    <= 1'b0;
                    out_next_pc <= tgt_pc;
                    st          <= S_IDLE;
                end
                S_CALL: begin
                    if (call_done) begin
                        call_req    <= 1'b0;
                        out_done    <= 1'b1;
                        out_taken   <= 1'b0;
                        out_exit    <= 1'b0;
                        out_next_pc <= tgt_pc;
                        st          <= S_IDLE;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // Exit reports on the edge after acceptance
    AST_EXIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        accept && in_opcode == 8'h95 |=> out_done && out_exit && !out_taken); // R9

    // Jumps report after exactly two edges
    AST_JUMP_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
        accept && (dec_kind == K_JUMP || dec_kind == K_BAD)
        |=> !out_done && !in_ready ##1 out_done && !out_exit); // R8

    // A waiting call holds its request and reports nothing
    AST_CALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        call_req && !call_done |=> call_req && !out_done); // R10

    // No report in the cycle a call request appears
    AST_CALL_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(call_req) |-> !out_done); // R10

    // A handler strobe outside a call raises nothing
    AST_STRAY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !call_req && call_done && !(accept && in_opcode == 8'h85) |=> !call_req); // R11

    // Ready whenever a result is shown
    AST_READY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |-> in_ready); // R13

endmodule

// File: tb/sim_bru_top.sv
`timescale 1ns/1ps
module sim_bru_top;

    localparam int XLEN  = 64;
    localparam int PC_W  = 32;
    localparam int OFF_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [7:0]       in_opcode = '0;
    logic [XLEN-1:0]  in_dst = '0;
    logic [XLEN-1:0]  in_src = '0;
    logic [XLEN-1:0]  in_imm = '0;
    logic [OFF_W-1:0] in_off = '0;
    logic [PC_W-1:0]  in_pc = '0;
    logic             out_done;
    logic             out_taken;
    logic             out_exit;
    logic [PC_W-1:0]  out_next_pc;
    logic             call_req;
    logic             call_done = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    bru_top #(.XLEN(XLEN), .PC_W(PC_W), .OFF_W(OFF_W)) u0 (
        .clk, .rst_n, .in_valid, .in_ready, .in_opcode, .in_dst, .in_src,
        .in_imm, .in_off, .in_pc, .out_done, .out_taken, .out_exit,
        .out_next_pc, .call_req, .call_done
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [PC_W-1:0] exp_pc(input logic [PC_W-1:0] pc,
                                               input logic [OFF_W-1:0] off,
                                               input bit taken);
        logic [PC_W-1:0] ext;
        ext = {{(PC_W-OFF_W){off[OFF_W-1]}}, off};
        return taken ? pc + ext + 1 : pc + 1;
    endfunction

    // Issue one instruction and check latency and result.
    // call_wait: negedge index at which call_done is driven (0 = never)
    // stray: pulse call_done during the evaluation cycle
    task automatic run_op(input string req, input logic [7:0] op,
                          input logic [63:0] dst, input logic [63:0] src,
                          input logic [63:0] imm, input logic [15:0] off,
                          input logic [31:0] pc, input bit exp_taken,
                          input int exp_lat, input bit is_exit,
                          input int call_wait, input bit stray);
        int n;
        logic [PC_W-1:0] epc;
        @(negedge clk);
        in_valid = 1'b1; in_opcode = op; in_dst = dst; in_src = src;
        in_imm = imm; in_off = off; in_pc = pc;
        n = 0;
        while (1) begin
            @(negedge clk);
            n++;
            if (n == 1) begin
                in_valid = 1'b0;
                if (call_wait > 0)
                    chk(call_req == 1'b1, "R10", "call_req raised", 64'(call_req), 64'd1);
                if (stray)
                    chk(call_req == 1'b0, "R11", "no call_req on stray", 64'(call_req), 64'd0);
            end
            call_done = 1'b0;
            if (stray && n == 1 && !out_done) call_done = 1'b1;
            if (call_wait > 0 && n == call_wait) call_done = 1'b1;
            if (out_done || n > 50) break;
            if (exp_lat == 2)
                chk(in_ready == 1'b0, "R8", "busy between edges", 64'(in_ready), 64'd0);
        end
        call_done = 1'b0;
        epc = is_exit ? pc : exp_pc(pc, off, exp_taken);
        chk(n == exp_lat, req, "latency", 64'(n), 64'(exp_lat));
        chk(out_taken == exp_taken, req, "taken", 64'(out_taken), 64'(exp_taken));
        chk(out_exit == is_exit, req, "exit flag", 64'(out_exit), 64'(is_exit));
        chk(out_next_pc == epc, "R7", {req, " next pc"}, 64'(out_next_pc), 64'(epc));
    endtask

    task automatic t_reset();
        chk(in_ready == 1'b1, "R1", "ready after reset", 64'(in_ready), 64'd1);
        chk(out_done == 1'b0, "R1", "done after reset", 64'(out_done), 64'd0);
        chk(call_req == 1'b0, "R1", "call_req after reset", 64'(call_req), 64'd0);
    endtask

    task automatic t_uncond();
        run_op("R3", 8'h05, 64'd1, 64'd2, 64'd3, 16'hFFFD, 32'd100, 1, 2, 0, 0, 0);
        run_op("R3", 8'h05, 64'd0, 64'd0, 64'd0, 16'd7, 32'd10, 1, 2, 0, 0, 0);
    endtask

    task automatic t_operand_select();
        run_op("R2", 8'h15, 64'd9, 64'd5, 64'd9, 16'd4, 32'd20, 1, 2, 0, 0, 0);
        run_op("R2", 8'h1D, 64'd9, 64'd5, 64'd9, 16'd4, 32'd20, 0, 2, 0, 0, 0);
        run_op("R2", 8'h1D, 64'd5, 64'd5, 64'd9, 16'd4, 32'd20, 1, 2, 0, 0, 0);
    endtask

    task automatic t_eq_ne_set();
        run_op("R4", 8'h55, 64'd3, 64'd0, 64'd4, 16'd2, 32'd30, 1, 2, 0, 0, 0);
        run_op("R4", 8'h5D, 64'd3, 64'd3, 64'd4, 16'd2, 32'd30, 0, 2, 0, 0, 0);
        run_op("R4", 8'h45, 64'h10, 64'd0, 64'h30, 16'd1, 32'd40, 1, 2, 0, 0, 0);
        run_op("R4", 8'h4D, 64'h10, 64'h0F, 64'h10, 16'd1, 32'd40, 0, 2, 0, 0, 0);
    endtask

    task automatic t_unsigned();
        run_op("R5", 8'h2D, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'd0, 16'd5, 32'd50, 1, 2, 0, 0, 0);
        run_op("R5", 8'h35, 64'd7, 64'd0, 64'd7, 16'd5, 32'd50, 1, 2, 0, 0, 0);
        run_op("R5", 8'hA5, 64'd1, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF, 16'd5, 32'd50, 1, 2, 0, 0, 0);
        run_op("R5", 8'hBD, 64'd8, 64'd7, 64'd0, 16'd5, 32'd50, 0, 2, 0, 0, 0);
    endtask

    task automatic t_signed();
        run_op("R6", 8'h6D, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'd0, 16'd5, 32'd60, 0, 2, 0, 0, 0);
        run_op("R6", 8'hC5, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 64'd0, 16'd5, 32'd60, 1, 2, 0, 0, 0);
        run_op("R6", 8'h75, 64'h8000_0000_0000_0000, 64'd0, 64'd0, 16'd5, 32'd60, 0, 2, 0, 0, 0);
        run_op("R6", 8'hDD, 64'd4, 64'd4, 64'd0, 16'd5, 32'd60, 1, 2, 0, 0, 0);
    endtask

    task automatic t_pc_wrap();
        run_op("R7", 8'h05, 64'd0, 64'd0, 64'd0, 16'd0, 32'hFFFF_FFFF, 1, 2, 0, 0, 0);
        run_op("R7", 8'h15, 64'd1, 64'd0, 64'd2, 16'h8000, 32'd70, 0, 2, 0, 0, 0);
    endtask

    task automatic t_exit();
        run_op("R9", 8'h95, 64'd0, 64'd0, 64'd0, 16'd9, 32'd80, 0, 1, 1, 0, 0);
    endtask

    task automatic t_call();
        run_op("R10", 8'h85, 64'd0, 64'd0, 64'd0, 16'd9, 32'd90, 0, 6, 0, 5, 0);
        run_op("R10", 8'h85, 64'd0, 64'd0, 64'd0, 16'd9, 32'd91, 0, 2, 0, 1, 0);
    endtask

    task automatic t_stray_done();
        run_op("R11", 8'h15, 64'd2, 64'd0, 64'd2, 16'd3, 32'd95, 1, 2, 0, 0, 1);
        @(negedge clk);
        call_done = 1'b1;
        @(negedge clk);
        call_done = 1'b0;
        chk(call_req == 1'b0 && out_done == 1'b0, "R11", "idle strobe ignored",
            64'({call_req, out_done}), 64'd0);
    endtask

    task automatic t_bad_ops();
        run_op("R12", 8'h0D, 64'd0, 64'd0, 64'd0, 16'd5, 32'd110, 0, 2, 0, 0, 0);
        run_op("R12", 8'h9D, 64'd0, 64'd0, 64'd0, 16'd5, 32'd111, 0, 2, 0, 0, 0);
        run_op("R12", 8'hE5, 64'd0, 64'd0, 64'd0, 16'd5, 32'd112, 0, 2, 0, 0, 0);
        run_op("R12", 8'h17, 64'd1, 64'd1, 64'd1, 16'd5, 32'd113, 0, 2, 0, 0, 0);
    endtask

    // Report and issue in the same cycle
    task automatic t_back_to_back();
        int n;
        @(negedge clk);
        in_valid = 1'b1; in_opcode = 8'h05; in_off = 16'd2; in_pc = 32'd200;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk(out_done == 1'b1, "R13", "first done", 64'(out_done), 64'd1);
        chk(in_ready == 1'b1, "R13", "ready at done", 64'(in_ready), 64'd1);
        in_valid = 1'b1; in_opcode = 8'h1D; in_dst = 64'd6; in_src = 64'd6;
        in_imm = 64'd0; in_off = 16'd10; in_pc = 32'd300;
        chk(out_next_pc == 32'd203, "R13", "first result intact", 64'(out_next_pc), 64'd203);
        n = 0;
        while (1) begin
            @(negedge clk);
            n++;
            in_valid = 1'b0;
            if (out_done || n > 50) break;
        end
        chk(n == 2, "R13", "second latency", 64'(n), 64'd2);
        chk(out_taken == 1'b1, "R13", "second taken", 64'(out_taken), 64'd1);
        chk(out_next_pc == 32'd311, "R13", "second next pc", 64'(out_next_pc), 64'd311);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_uncond();
        t_operand_select();
        t_eq_ne_set();
        t_unsigned();
        t_signed();
        t_pc_wrap();
        t_exit();
        t_call();
        t_stray_done();
        t_bad_ops();
        t_back_to_back();
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule